// File: doc/BRIEF.md
# In-Band Loopback Code Generator

This block produces an unframed serial test stream that tells the far end of a line to close or open a loopback. Each transmit clock yields one unipolar bit, and the stream repeats one short code word without a break. Two register bits choose the word. An enable bit starts the stream. A select bit picks the loop-up word `00001` or the loop-down word `001`. Each word is sent first bit first. The generator runs only when the surrounding device is under register (host) control. In any other state the output is idle.

A test engineer can corrupt the stream on purpose through an asynchronous error strobe. The strobe is brought into the clock domain by a two-flop synchronizer and then edge-detected. Each rising edge inverts exactly one outgoing bit. A strobe that stays low or stays high changes nothing. When the select bits change, the new word starts at its first bit on the next clock. When the generator is turned off, its phase is cleared.

Top module: `inband_loop_code_gen`

## Requirements
- R1: While `host_mode_i` is 0 or `pat_en_i` is 0, the clock edge drives `data_o` to 0 and `valid_o` to 0. Both outputs are 0 out of reset.
- R2: With `pat_sel_i` = 0, the output after each edge repeats the loop-up sequence 0,0,0,0,1. The first bit appears on the edge that samples the enable.
- R3: With `pat_sel_i` = 1, the output after each edge repeats the loop-down sequence 0,0,1.
- R4: The select encoding is as follows: `pat_en_i` = 1 with `pat_sel_i` = 0 sends loop-up, and `pat_en_i` = 1 with `pat_sel_i` = 1 sends loop-down.
- R5: A change of `pat_sel_i` while active restarts the newly selected word at its first bit on the next edge.
- R6: A rising edge on `err_strobe_i` inverts exactly one bit. It is the bit that appears on the third clock edge after the strobe is driven high (two synchronizer flops and one edge flop).
- R7: Holding `err_strobe_i` low, holding it high, or its falling edge causes no inversion.
- R8: A rising edge of the strobe that is detected while the generator is idle is dropped, and no later bit is inverted.
- R9: When the generator is re-activated after being idle, the word restarts at its first bit.
- R10: `valid_o` is 1 on the edge after `host_mode_i` and `pat_en_i` are both sampled as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | Device is under register control |
| pat_en_i | input | 1 | Code generation enable bit |
| pat_sel_i | input | 1 | 0 selects loop-up, 1 selects loop-down |
| err_strobe_i | input | 1 | Asynchronous error-insert strobe; each rising edge inverts one bit |
| data_o | output | 1 | Serial unipolar code bit |
| valid_o | output | 1 | Code stream is being sent |

## Verification
A phase counter that runs past the end of a word, or that is not cleared on a restart, shows up within one word length. The output then breaks its period, or the first bit after enable or after a change of select is wrong. A faulty edge detector or synchronizer shows up within a few bits after the strobe. The symptom is no inversion, an inversion in the wrong slot, or a second inversion while the strobe is held high or after it falls. A stale enable register is visible on the very next edge, through `valid_o` or a non-zero idle bit.

// File: rtl/loop_code_pkg.sv
package loop_code_pkg;
  localparam int unsigned UP_LEN_DEF = 5;
  localparam logic [UP_LEN_DEF-1:0] UP_WORD_DEF = 5'b00001;
  localparam int unsigned DN_LEN_DEF = 3;
  localparam logic [DN_LEN_DEF-1:0] DN_WORD_DEF = 3'b001;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    SEL_UP = 1'b0,
    SEL_DN = 1'b1
  } code_sel_e;
endpackage

// File: rtl/loop_code_edge.sv
module loop_code_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  // sync chain plus one extra flop for edge detection
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], strobe_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/loop_code_phase.sv
module loop_code_phase #(
  parameter int unsigned UP_LEN = 5,
  parameter int unsigned DN_LEN = 3,
  parameter int unsigned PH_W   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            sel_i,
  output logic            restart_o,
  output logic [PH_W-1:0] cur_ph_o,
  output logic [PH_W-1:0] ph_q_o
);
  localparam logic [PH_W-1:0] UP_LAST = PH_W'(UP_LEN - 1);
  localparam logic [PH_W-1:0] DN_LAST = PH_W'(DN_LEN - 1);

  logic            active_q, sel_q;
  logic [PH_W-1:0] ph_q, last, nxt;

  assign restart_o = !active_q || (sel_i != sel_q);
  assign cur_ph_o  = restart_o ? '0 : ph_q;
  assign last      = sel_i ? DN_LAST : UP_LAST;
  assign nxt       = (cur_ph_o == last) ? '0 : cur_ph_o + 1'b1;
  assign ph_q_o    = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      active_q <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      ph_q     <= active_i ? nxt : '0;
      active_q <= active_i;
      sel_q    <= sel_i;
    end
  end
endmodule

// File: rtl/loop_code_out.sv
module loop_code_out #(
  parameter int unsigned       UP_LEN  = 5,
  parameter logic [UP_LEN-1:0] UP_WORD = 5'b00001,
  parameter int unsigned       DN_LEN  = 3,
  parameter logic [DN_LEN-1:0] DN_WORD = 3'b001,
  parameter int unsigned       PH_W    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            sel_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            flip_i,
  output logic            data_o,
  output logic            valid_o
);
  localparam int unsigned TBL = 1 << PH_W;

  // bit tables indexed by phase, first transmitted bit = word MSB
  logic [TBL-1:0] up_tbl, dn_tbl;

  for (genvar p = 0; p < TBL; p++) begin : g_tbl
    if (p < UP_LEN) begin : g_up
      assign up_tbl[p] = UP_WORD[UP_LEN-1-p];
    end else begin : g_up_pad
      assign up_tbl[p] = 1'b0;
    end
    if (p < DN_LEN) begin : g_dn
      assign dn_tbl[p] = DN_WORD[DN_LEN-1-p];
    end else begin : g_dn_pad
      assign dn_tbl[p] = 1'b0;
    end
  end

  logic code_bit;
  assign code_bit = sel_i ? dn_tbl[ph_i] : up_tbl[ph_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= active_i & (code_bit ^ flip_i);
      valid_o <= active_i;
    end
  end
endmodule

// File: rtl/inband_loop_code_gen.sv
module inband_loop_code_gen #(
  parameter int unsigned       UP_LEN      = loop_code_pkg::UP_LEN_DEF,
  parameter logic [UP_LEN-1:0] UP_WORD     = loop_code_pkg::UP_WORD_DEF,
  parameter int unsigned       DN_LEN      = loop_code_pkg::DN_LEN_DEF,
  parameter logic [DN_LEN-1:0] DN_WORD     = loop_code_pkg::DN_WORD_DEF,
  parameter int unsigned       SYNC_STAGES = loop_code_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_mode_i,
  input  logic pat_en_i,
  input  logic pat_sel_i,
  input  logic err_strobe_i,
  output logic data_o,
  output logic valid_o
);
  localparam int unsigned MAX_LEN = (UP_LEN > DN_LEN) ? UP_LEN : DN_LEN;
  localparam int unsigned PH_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic            active, rise, flip, restart;
  logic [PH_W-1:0] cur_ph, ph_q;

  assign active = host_mode_i & pat_en_i;
  // an edge seen while idle is dropped
  assign flip   = rise & active;

  loop_code_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(err_strobe_i),
    .rise_o  (rise)
  );

  loop_code_phase #(
    .UP_LEN(UP_LEN),
    .DN_LEN(DN_LEN),
    .PH_W  (PH_W)
  ) i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .sel_i    (pat_sel_i),
    .restart_o(restart),
    .cur_ph_o (cur_ph),
    .ph_q_o   (ph_q)
  );

  loop_code_out #(
    .UP_LEN (UP_LEN),
    .UP_WORD(UP_WORD),
    .DN_LEN (DN_LEN),
    .DN_WORD(DN_WORD),
    .PH_W   (PH_W)
  ) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .sel_i   (pat_sel_i),
    .ph_i    (cur_ph),
    .flip_i  (flip),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/loop_code_chk.sv
module loop_code_chk #(
  parameter int unsigned       UP_LEN  = 5,
  parameter logic [UP_LEN-1:0] UP_WORD = 5'b00001,
  parameter int unsigned       DN_LEN  = 3,
  parameter logic [DN_LEN-1:0] DN_WORD = 3'b001,
  parameter int unsigned       PH_W    = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            host_mode_i,
  input logic            pat_en_i,
  input logic            pat_sel_i,
  input logic            data_o,
  input logic            valid_o,
  input logic            restart,
  input logic            rise,
  input logic [PH_W-1:0] ph_q
);
  localparam logic UP_FIRST = UP_WORD[UP_LEN-1];
  localparam logic DN_FIRST = DN_WORD[DN_LEN-1];

  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_mode_i && pat_en_i) |=> (!valid_o && !data_o)); // R1

  AST_VALID_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && pat_en_i) |=> valid_o); // R10

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && pat_en_i) |=> (ph_q < ($past(pat_sel_i) ? PH_W'(DN_LEN) : PH_W'(UP_LEN)))); // R2

  AST_RESTART_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && pat_en_i && restart && !rise)
      |=> (data_o == ($past(pat_sel_i) ? DN_FIRST : UP_FIRST))); // R5

  AST_EDGE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise); // R6
endmodule

bind inband_loop_code_gen loop_code_chk #(
  .UP_LEN (UP_LEN),
  .UP_WORD(UP_WORD),
  .DN_LEN (DN_LEN),
  .DN_WORD(DN_WORD),
  .PH_W   (PH_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_mode_i(host_mode_i),
  .pat_en_i   (pat_en_i),
  .pat_sel_i  (pat_sel_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .restart    (restart),
  .rise       (rise),
  .ph_q       (ph_q)
);

// File: tb/test_inband_loop_code_gen.sv
module test_inband_loop_code_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host = 1'b0, en = 1'b0, sel = 1'b0, strobe = 1'b0;
  logic dout, vld;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  inband_loop_code_gen i_inband_loop_code_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .host_mode_i (host),
    .pat_en_i    (en),
    .pat_sel_i   (sel),
    .err_strobe_i(strobe),
    .data_o      (dout),
    .valid_o     (vld)
  );

  // loop-up 00001, loop-down 001, first bit first
  function automatic logic exp_bit(logic s, int idx);
    return s ? (idx % 3 == 2) : (idx % 5 == 4);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(logic s, int start, int n, string req);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(dout == exp_bit(s, start + i) && vld, req, {vld, dout}, {1'b1, exp_bit(s, start + i)});
    end
  endtask

  task automatic go_idle();
    en = 1'b0;
    tick();
    chk(!dout && !vld, "R1 idle", {vld, dout}, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!dout && !vld, "R1 reset", {vld, dout}, 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk(!dout && !vld, "R1 en low", {vld, dout}, 0);
  endtask

  task automatic t_up();
    go_idle();
    host = 1'b1; sel = 1'b0; en = 1'b1;
    run(1'b0, 0, 15, "R2 R4 R10 loop-up");
  endtask

  task automatic t_down();
    go_idle();
    sel = 1'b1; en = 1'b1;
    run(1'b1, 0, 12, "R3 R4 loop-down");
  endtask

  task automatic t_switch();
    go_idle();
    sel = 1'b0; en = 1'b1;
    run(1'b0, 0, 2, "R2 pre-switch");
    sel = 1'b1;
    run(1'b1, 0, 4, "R5 switch to down");
    sel = 1'b0;
    run(1'b0, 0, 6, "R5 switch to up");
  endtask

  task automatic t_host_off();
    run(1'b0, 6, 2, "R2 continue");
    host = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(!dout && !vld, "R1 host off", {vld, dout}, 0);
    end
    host = 1'b1;
    run(1'b0, 0, 5, "R9 restart");
  endtask

  task automatic t_err(logic s);
    int mis = 0, pos = -1;
    go_idle();
    sel = s; en = 1'b1;
    run(s, 0, 3, "R6 pre-error");
    strobe = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (dout != exp_bit(s, 3 + i)) begin
        mis++;
        pos = i;
      end
    end
    chk(mis == 1, "R6 one inversion", mis, 1);
    chk(pos == 2, "R6 inversion slot", pos, 2);
    strobe = 1'b0;
    run(s, 15, 10, "R7 falling edge");
  endtask

  task automatic t_err_low();
    go_idle();
    sel = 1'b1; en = 1'b1;
    run(1'b1, 0, 20, "R7 strobe low");
  endtask

  task automatic t_err_idle();
    go_idle();
    strobe = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    strobe = 1'b0;
    tick();
    tick();
    sel = 1'b0; en = 1'b1;
    run(1'b0, 0, 10, "R8 edge while idle");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_up();
    t_down();
    t_switch();
    t_host_off();
    t_err(1'b0);
    t_err(1'b1);
    t_err_low();
    t_err_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule